// File: doc/BRIEF.md
# Microprogram Sequencer with Writable Control Store

This block is the control unit of a microprogrammed processor. A writable control store holds microinstructions. A microprogram counter points at the word being run, and a microinstruction register holds that word. On every clock the register drives the datapath control groups (ALU function, result-register write enables, memory command, operand-bus source). In the same cycle the block works out which word to fetch next.

Every microinstruction names its own successor. A three-bit jump field can change that successor in two ways. Two of its bits set the top address bit from the negative and zero flags, which gives a two-way branch. The third bit ORs the fetched opcode byte into the low address bits, which gives a multiway dispatch. A write port lets the surrounding system or a testbench place a microprogram in the store. The store can be written both during reset and while the sequencer runs.

After reset is released, the first edge only primes the register with the word at address 0. Normal sequencing starts on the following edge.

Top module: `useq_sequencer`

## Requirements
- R1: While rst_n is low, mpc, next_mpc, alu_ctl, c_sel, mem_ctl and b_sel are all zero.
- R2: On the first rising clock edge after rst_n goes high, the register is loaded with the word at address 0, and mpc stays 0.
- R3: A 36-bit word is laid out from the most significant bit down as successor address [35:27], jump field [26:24], ALU function [23:16], register write enables [15:7], memory command [6:4] and bus source [3:0]. The last four groups appear unchanged on alu_ctl, c_sel, mem_ctl and b_sel.
- R4: With a jump field of 000, next_mpc equals the successor address.
- R5: When jump bit 25 is set and n_flag is high, bit 8 of next_mpc is 1.
- R6: When jump bit 24 is set and z_flag is high, bit 8 of next_mpc is 1.
- R7: When jump bit 26 is set, next_mpc[7:0] is successor[7:0] OR mbr. Bit 8 follows only the successor bit and the flag terms.
- R8: On each edge after priming, mpc takes the value next_mpc had before the edge, and the outputs show the store word at that address.
- R9: A word written through the write port is returned by every later fetch of that address, whether it was written during reset or while running. A fetch in the same edge as the write returns the old word.
- R10: n_flag, z_flag and mbr have no effect on next_mpc when their jump bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store write strobe |
| wr_addr | input | 9 | Store write address |
| wr_data | input | 36 | Microinstruction to write |
| n_flag | input | 1 | Datapath result negative |
| z_flag | input | 1 | Datapath result zero |
| mbr | input | 8 | Fetched opcode byte for dispatch |
| mpc | output | 9 | Address of the word in the register |
| next_mpc | output | 9 | Address fetched at the coming edge |
| alu_ctl | output | 8 | ALU and shifter function |
| c_sel | output | 9 | Result-register write enables |
| mem_ctl | output | 3 | Memory command |
| b_sel | output | 4 | Operand-bus source select |

## Verification
The bench builds the block with its default widths: a 9-bit address, so the full 512-word store, and a 36-bit word. Every word of the store is filled with a computed pattern that mixes all eight jump codes. The top address half is therefore reached through both flag branches and through plain successors, and opcode dispatch lands across the whole low half. The store is rewritten while the sequencer runs, and a second reset is applied in mid-run, so priming from address 0 and write-then-fetch ordering are both exercised.

// File: rtl/useq_pkg.sv
package useq_pkg;

    // Bit positions inside the three-bit jump field; the next-address logic
    // and the checker both decode these.
    localparam int JMP_W      = 3;
    localparam int JMP_DISP   = 2;
    localparam int JMP_NEG    = 1;
    localparam int JMP_ZERO   = 0;

    typedef enum logic {
        PH_PRIME = 1'b0,
        PH_RUN   = 1'b1
    } phase_e;

endpackage

// File: rtl/useq_store.sv
module useq_store #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 36
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Read is combinational; the sequencer register captures it, so a
    // same-edge write is seen only by later fetches.
    assign rd_data = words[rd_addr];

endmodule

// File: rtl/useq_field_split.sv
module useq_field_split #(
    parameter int ADDR_W = 9,
    parameter int ALU_W  = 8,
    parameter int CSEL_W = 9,
    parameter int MEM_W  = 3,
    parameter int BSEL_W = 4
) (
    input  logic [ADDR_W+useq_pkg::JMP_W+ALU_W+CSEL_W+MEM_W+BSEL_W-1:0] word,
    output logic [ADDR_W-1:0]          succ,
    output logic [useq_pkg::JMP_W-1:0] jmp,
    output logic [ALU_W-1:0]           alu,
    output logic [CSEL_W-1:0]          csel,
    output logic [MEM_W-1:0]           mem,
    output logic [BSEL_W-1:0]          bsel
);
    localparam int B_LO    = 0;
    localparam int MEM_LO  = B_LO + BSEL_W;
    localparam int C_LO    = MEM_LO + MEM_W;
    localparam int ALU_LO  = C_LO + CSEL_W;
    localparam int JMP_LO  = ALU_LO + ALU_W;
    localparam int SUCC_LO = JMP_LO + useq_pkg::JMP_W;

    assign bsel = word[B_LO    +: BSEL_W];
    assign mem  = word[MEM_LO  +: MEM_W];
    assign csel = word[C_LO    +: CSEL_W];
    assign alu  = word[ALU_LO  +: ALU_W];
    assign jmp  = word[JMP_LO  +: useq_pkg::JMP_W];
    assign succ = word[SUCC_LO +: ADDR_W];

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
    parameter int ADDR_W = 9
) (
    input  logic [ADDR_W-1:0]          succ,
    input  logic [useq_pkg::JMP_W-1:0] jmp,
    input  logic                       n_flag,
    input  logic                       z_flag,
    input  logic [ADDR_W-2:0]          opcode,
    output logic [ADDR_W-1:0]          next
);
    import useq_pkg::*;

    logic             hi_bit;
    logic [ADDR_W-2:0] lo_bits;

    always_comb begin
        hi_bit = succ[ADDR_W-1]
               | (jmp[JMP_NEG]  & n_flag)
               | (jmp[JMP_ZERO] & z_flag);
        lo_bits = succ[ADDR_W-2:0];
        if (jmp[JMP_DISP]) begin
            lo_bits = lo_bits | opcode;
        end
        next = {hi_bit, lo_bits};
    end

endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer #(
    parameter int ADDR_W = 9,
    parameter int ALU_W  = 8,
    parameter int CSEL_W = 9,
    parameter int MEM_W  = 3,
    parameter int BSEL_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [ADDR_W+useq_pkg::JMP_W+ALU_W+CSEL_W+MEM_W+BSEL_W-1:0] wr_data,
    input  logic                 n_flag,
    input  logic                 z_flag,
    input  logic [ADDR_W-2:0]    mbr,
    output logic [ADDR_W-1:0]    mpc,
    output logic [ADDR_W-1:0]    next_mpc,
    output logic [ALU_W-1:0]     alu_ctl,
    output logic [CSEL_W-1:0]    c_sel,
    output logic [MEM_W-1:0]     mem_ctl,
    output logic [BSEL_W-1:0]    b_sel
);
    import useq_pkg::*;

    localparam int WORD_W = ADDR_W + JMP_W + ALU_W + CSEL_W + MEM_W + BSEL_W;

    typedef struct packed {
        phase_e            phase;
        logic [ADDR_W-1:0] mpc;
        logic [WORD_W-1:0] mir;
    } seq_s;

    seq_s cur_q;
    seq_s nxt_d;

    logic [ADDR_W-1:0] succ;
    logic [JMP_W-1:0]  jmp;
    logic [ADDR_W-1:0] cand_addr;
    logic [ADDR_W-1:0] fetch_addr;
    logic [WORD_W-1:0] fetch_word;
    logic [WORD_W-1:0] mir_word;

    assign mir_word = cur_q.mir;

    useq_field_split #(
        .ADDR_W (ADDR_W),
        .ALU_W  (ALU_W),
        .CSEL_W (CSEL_W),
        .MEM_W  (MEM_W),
        .BSEL_W (BSEL_W)
    ) split_i (
        .word (cur_q.mir),
        .succ (succ),
        .jmp  (jmp),
        .alu  (alu_ctl),
        .csel (c_sel),
        .mem  (mem_ctl),
        .bsel (b_sel)
    );

    useq_next_addr #(
        .ADDR_W (ADDR_W)
    ) nxt_i (
        .succ   (succ),
        .jmp    (jmp),
        .n_flag (n_flag),
        .z_flag (z_flag),
        .opcode (mbr),
        .next   (cand_addr)
    );

    useq_store #(
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W)
    ) store_i (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (fetch_addr),
        .rd_data (fetch_word)
    );

    // While priming, fetch the entry word rather than the computed successor.
    assign fetch_addr = (cur_q.phase == PH_PRIME) ? '0 : cand_addr;

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.phase = PH_RUN;
        nxt_d.mpc   = fetch_addr;
        nxt_d.mir   = fetch_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{phase: PH_PRIME, mpc: '0, mir: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mpc      = cur_q.mpc;
    assign next_mpc = fetch_addr;

endmodule

// File: rtl/useq_checker.sv
module useq_checker #(
    parameter int ADDR_W = 9,
    parameter int WORD_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WORD_W-1:0] mir,
    input logic              n_flag,
    input logic              z_flag,
    input logic [ADDR_W-2:0] mbr,
    input logic [ADDR_W-1:0] mpc,
    input logic [ADDR_W-1:0] next_mpc,
    input logic              outs_zero
);
    import useq_pkg::*;

    localparam int JMP_LO  = WORD_W - ADDR_W - JMP_W;
    localparam int SUCC_LO = WORD_W - ADDR_W;

    logic [JMP_W-1:0]  jmp;
    logic [ADDR_W-1:0] succ;
    logic              primed;

    assign jmp  = mir[JMP_LO +: JMP_W];
    assign succ = mir[SUCC_LO +: ADDR_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            primed <= 1'b0;
        end else begin
            primed <= 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> (mpc == '0 && next_mpc == '0 && outs_zero)); // R1

    AST_PRIME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |=> (mpc == '0)); // R2

    AST_MPC_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        primed |=> (mpc == $past(next_mpc))); // R8

    AST_PLAIN_SUCC: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && jmp == '0) |-> (next_mpc == succ)); // R4

    AST_NEG_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && jmp[JMP_NEG] && n_flag) |-> next_mpc[ADDR_W-1]); // R5

    AST_ZERO_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && jmp[JMP_ZERO] && z_flag) |-> next_mpc[ADDR_W-1]); // R6

    AST_DISPATCH_OR: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && jmp[JMP_DISP]) |-> ((next_mpc[ADDR_W-2:0] & mbr) == mbr)); // R7

endmodule

bind useq_sequencer useq_checker #(
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mir       (mir_word),
    .n_flag    (n_flag),
    .z_flag    (z_flag),
    .mbr       (mbr),
    .mpc       (mpc),
    .next_mpc  (next_mpc),
    .outs_zero (alu_ctl == '0 && c_sel == '0 && mem_ctl == '0 && b_sel == '0)
);

// File: tb/useq_sequencer_tb_top.sv
module useq_sequencer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [8:0]  wr_addr = '0;
    logic [35:0] wr_data = '0;
    logic        n_flag = 1'b0;
    logic        z_flag = 1'b0;
    logic [7:0]  mbr = '0;
    logic [8:0]  mpc;
    logic [8:0]  next_mpc;
    logic [7:0]  alu_ctl;
    logic [8:0]  c_sel;
    logic [2:0]  mem_ctl;
    logic [3:0]  b_sel;

    always #2 clk = ~clk;

    useq_sequencer dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .n_flag   (n_flag),
        .z_flag   (z_flag),
        .mbr      (mbr),
        .mpc      (mpc),
        .next_mpc (next_mpc),
        .alu_ctl  (alu_ctl),
        .c_sel    (c_sel),
        .mem_ctl  (mem_ctl),
        .b_sel    (b_sel)
    );

    // ---------------- reference model ----------------
    logic [35:0] ref_mem [512];
    logic [8:0]  ref_mpc = '0;
    logic [35:0] ref_mir = '0;
    bit          ref_primed = 1'b0;
    bit          ref_just_primed = 1'b0;
    logic [8:0]  ref_na;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string fld_tag = "R3";
    int    seed = 7;

    function automatic logic [8:0] ref_next(logic [35:0] w, logic n, logic z, logic [7:0] m);
        logic [8:0] a;
        logic [2:0] j;
        logic [8:0] r;
        a = w[35:27];
        j = w[26:24];
        r = a;
        if (j[1] && n) r[8] = 1'b1;
        if (j[0] && z) r[8] = 1'b1;
        if (j[2]) r[7:0] = a[7:0] | m;
        return r;
    endfunction

    function automatic logic [35:0] mkword(int i);
        logic [8:0] a;
        logic [2:0] j;
        a = 9'((i * 97 + 13) % 512);
        j = 3'((i / 3) % 8);
        return {a, j, 8'(i * 7 + 3), 9'(i * 5 + 1), 3'(i % 8), 4'((i + 9) % 16)};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_mpc = '0;
            ref_mir = '0;
            ref_primed = 1'b0;
            ref_just_primed = 1'b0;
        end else begin
            ref_na = ref_primed ? ref_next(ref_mir, n_flag, z_flag, mbr) : 9'd0;
            ref_just_primed = !ref_primed;
            ref_mir = ref_mem[ref_na];
            ref_mpc = ref_na;
            ref_primed = 1'b1;
        end
    end

    always @(posedge clk) begin
        if (wr_en) ref_mem[wr_addr] <= wr_data;
    end

    // ---------------- checking ----------------
    task automatic chk(string tag, string what, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 8) & 32'h7fff_ffff;
    endfunction

    // One cycle: compare registered outputs, drive new inputs, compare next_mpc.
    task automatic cyc(logic n_i, logic z_i, logic [7:0] m_i);
        string rt;
        string ft;
        string nt;
        logic [2:0] j;
        logic [8:0] exp_next;
        @(negedge clk);
        rt = !rst_n ? "R1" : (ref_just_primed ? "R2" : "R8");
        ft = !rst_n ? "R1" : fld_tag;
        chk(rt, "mpc", 36'(mpc), 36'(ref_mpc));
        chk(ft, "alu_ctl", 36'(alu_ctl), 36'(ref_mir[23:16]));
        chk(ft, "c_sel",   36'(c_sel),   36'(ref_mir[15:7]));
        chk(ft, "mem_ctl", 36'(mem_ctl), 36'(ref_mir[6:4]));
        chk(ft, "b_sel",   36'(b_sel),   36'(ref_mir[3:0]));
        n_flag = n_i;
        z_flag = z_i;
        mbr    = m_i;
        #1;
        j = ref_mir[26:24];
        exp_next = (rst_n && ref_primed) ? ref_next(ref_mir, n_i, z_i, m_i) : 9'd0;
        if (!rst_n)      nt = "R1";
        else if (j[2])   nt = "R7";
        else if (j[1])   nt = "R5";
        else if (j[0])   nt = "R6";
        else if (n_i || z_i || m_i != 8'd0) nt = "R10";
        else             nt = "R4";
        chk(nt, "next_mpc", 36'(next_mpc), 36'(exp_next));
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R8 watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        int r;
        // Load the whole store while held in reset (R1, R9).
        for (int i = 0; i < 512; i++) begin
            wr_en   = 1'b1;
            wr_addr = 9'(i);
            wr_data = mkword(i);
            cyc(1'b1, 1'b1, 8'hff);
        end
        wr_en = 1'b0;
        cyc(1'b0, 1'b0, 8'h00);
        rst_n = 1'b1;
        // Priming edge then free run with varied flags and opcodes (R2-R8).
        for (int i = 0; i < 600; i++) begin
            r = rnd();
            cyc(r[0], r[1], 8'(r >> 2));
        end
        // Quiet inputs: plain successors only.
        for (int i = 0; i < 100; i++) begin
            cyc(1'b0, 1'b0, 8'h00);
        end
        // Flags and opcode all high: cleared jump bits must hide them (R10).
        for (int i = 0; i < 100; i++) begin
            cyc(1'b1, 1'b1, 8'hff);
        end
        // Rewrite the store while running (R9).
        fld_tag = "R9";
        for (int i = 0; i < 512; i++) begin
            wr_en   = 1'b1;
            wr_addr = 9'((i * 5) % 512);
            wr_data = mkword(i * 11 + 1000);
            r = rnd();
            cyc(r[3], r[4], 8'(r >> 5));
        end
        wr_en = 1'b0;
        for (int i = 0; i < 200; i++) begin
            r = rnd();
            cyc(r[0], r[2], 8'(r >> 4));
        end
        // Reset in mid-run, then prime again from address 0 (R1, R2).
        fld_tag = "R3";
        rst_n = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cyc(1'b1, 1'b0, 8'h5a);
        end
        rst_n = 1'b1;
        for (int i = 0; i < 60; i++) begin
            r = rnd();
            cyc(r[1], r[0], 8'(r >> 3));
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule